// File: doc/BRIEF.md
# Two-Port GPIO Expander Register Bank

This block is the register core of a 16-bit I/O expander built as two 8-bit ports. Every port has four registers: a sampled input image, an output latch, a polarity mask and a direction mask. The block drives a per-pin output enable and output level. It also samples the pin levels every clock. A serial-bus front end sits outside this block and drives a small byte interface: one strobe loads an access pointer, one strobe writes a byte, and one request reads a byte.

The register address is built as {kind, port}. Bit 0 picks the port. Bits 2:1 pick the kind: 0 is input, 1 is output, 2 is polarity and 3 is direction. After any data byte, the pointer flips bit 0, so a stream of bytes alternates between the two ports of the same kind. A read of an input register returns the sampled pin level XORed with the polarity mask. A read of an output register returns the latch, never the pin. Reset is synchronous and active high. While it is asserted it holds every register at its default.

Top module: `gpx_regbank`

## Requirements
- R1: While rst is high, every register stays at its default, whatever strobes arrive: output latches 0xFF, polarity 0x00, direction 0xFF. As a result pin_oe and pin_out are all zero. The pointer resets to 0.
- R2: Addresses 0..7 select, in order: input port 0, input port 1, output port 0, output port 1, polarity port 0, polarity port 1, direction port 0, direction port 1.
- R3: After each written or read byte, the pointer moves to the other register of its pair (address XOR 1), for any number of bytes. It never leaves the pair.
- R4: A read of input port p returns the pin levels sampled one clock earlier, XORed bitwise with polarity register p (1 inverts the bit, 0 keeps it). This holds whatever the direction of the pin.
- R5: Writes to addresses 0 and 1 change no register. The byte is discarded, and the pointer still advances.
- R6: A direction bit of 1 makes its pin an input: pin_oe is 0 and pin_out is 0. A direction bit of 0 sets pin_oe to 1 and drives pin_out from the output latch bit. Pin i of port p is bus bit 8*p+i.
- R7: A read of an output register returns the stored latch value, independent of pin_in.
- R8: Bit 3 of ptr_val is ignored, so a load of 8..15 selects address ptr_val-8.
- R9: When ptr_load arrives in the same cycle as a byte access, the access uses the newly loaded address, and the pointer then rests on its partner.
- R10: rd_data changes only on a read request. Later pin changes do not disturb a byte that has already been captured.
- R11: rd_valid is high for exactly the cycle after each rd_req, and rd_data is valid in that cycle.
- R12: A read and a write in the same cycle address the same register. The read returns the contents from before the write, the write takes effect, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptr_load | input | 1 | Load the access pointer from ptr_val |
| ptr_val | input | 4 | Pointer value; bit 3 ignored |
| wr_stb | input | 1 | Write wr_data to the addressed register |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Capture the addressed register into rd_data |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | rd_data was captured on the last edge |
| pin_in | input | 16 | Sampled pin levels, port 1 in the upper byte |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output level |

## Verification
The collisions that matter are a pointer load landing in the same cycle as a data byte, and a read landing in the same cycle as a write to the same register. The bench raises ptr_load together with rd_req or wr_stb in one cycle. It judges the result from the returned byte and from the partner register that the next plain access reaches. It also raises rd_req and wr_stb together on an output latch. It expects the old byte on rd_data, the new byte on a later read-back and on pin_out, and a single pointer step.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [1:0] {
    K_INPUT  = 2'd0,
    K_OUTPUT = 2'd1,
    K_POLAR  = 2'd2,
    K_DIR    = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpx_pointer.sv
module gpx_pointer #(
  parameter int ADDR_W = 3,
  parameter int LOAD_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              access,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [ADDR_W-1:0] ptr_nx;

  // loaded value is used by an access in the same cycle
  assign eff_addr = load ? load_val[ADDR_W-1:0] : ptr_q;
  assign ptr_nx   = access ? {eff_addr[ADDR_W-1:1], ~eff_addr[0]} : eff_addr;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_nx;
  end

  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (access && !load) |=> (ptr_q[ADDR_W-1:1] == $past(ptr_q[ADDR_W-1:1]) &&
                           ptr_q[0] != $past(ptr_q[0])));
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!access && !load) |=> $stable(ptr_q));
  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (load && !access) |=> (ptr_q == $past(load_val[ADDR_W-1:0])));
  p_load_access_r9: assert property (@(posedge clk) disable iff (rst)
    (load && access) |=> (ptr_q[ADDR_W-1:1] == $past(load_val[ADDR_W-1:1]) &&
                          ptr_q[0] != $past(load_val[0])));
endmodule

// File: rtl/gpx_store.sv
module gpx_store
  import gpx_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORT  = 2,
  localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  reg_kind_e                    kind,
  input  logic [SEL_W-1:0]             port_sel,
  input  logic [PORT_W-1:0]            wdata,
  output logic [NPORT-1:0][PORT_W-1:0] out_q,
  output logic [NPORT-1:0][PORT_W-1:0] pol_q,
  output logic [NPORT-1:0][PORT_W-1:0] dir_q,
  output logic [NPORT-1:0][PORT_W-1:0] pin_oe,
  output logic [NPORT-1:0][PORT_W-1:0] pin_out
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit = we && (port_sel == SEL_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[p] <= '1;
        pol_q[p] <= '0;
        dir_q[p] <= '1;
      end else if (hit) begin
        case (kind)
          K_OUTPUT: out_q[p] <= wdata;
          K_POLAR:  pol_q[p] <= wdata;
          K_DIR:    dir_q[p] <= wdata;
          default:  ; // input image is not writable
        endcase
      end
    end

    assign pin_oe[p]  = ~dir_q[p];
    assign pin_out[p] = out_q[p] & ~dir_q[p];
  end

  p_input_ro_r5: assert property (@(posedge clk) disable iff (rst)
    (we && kind == K_INPUT) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));
endmodule

// File: rtl/gpx_readpath.sv
module gpx_readpath
  import gpx_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORT  = 2,
  localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0][PORT_W-1:0] pin_in,
  input  logic [NPORT-1:0][PORT_W-1:0] out_q,
  input  logic [NPORT-1:0][PORT_W-1:0] pol_q,
  input  logic [NPORT-1:0][PORT_W-1:0] dir_q,
  input  logic                         rd_req,
  input  reg_kind_e                    kind,
  input  logic [SEL_W-1:0]             port_sel,
  output logic [PORT_W-1:0]            rd_data,
  output logic                         rd_valid
);
  logic [NPORT-1:0][PORT_W-1:0] in_q;
  logic [PORT_W-1:0]            sel_byte;

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= pin_in;
  end

  always_comb begin
    case (kind)
      K_INPUT:  sel_byte = in_q[port_sel] ^ pol_q[port_sel];
      K_OUTPUT: sel_byte = out_q[port_sel];
      K_POLAR:  sel_byte = pol_q[port_sel];
      default:  sel_byte = dir_q[port_sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= sel_byte;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));
  p_valid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  p_novalid_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
endmodule

// File: rtl/gpx_regbank.sv
module gpx_regbank
  import gpx_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int NPORT  = 2,
  localparam int PINS   = NPORT * PORT_W,
  localparam int LOAD_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_load,
  input  logic [LOAD_W-1:0] ptr_val,
  input  logic              wr_stb,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [PORT_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_out
);
  logic [ADDR_W-1:0]            eff_addr;
  logic [ADDR_W-1:0]            ptr_q;
  reg_kind_e                    kind;
  logic [0:0]                   port_sel;
  logic [NPORT-1:0][PORT_W-1:0] out_q, pol_q, dir_q, oe_w, drv_w, pins_w;

  assign kind     = reg_kind_e'(eff_addr[ADDR_W-1:1]);
  assign port_sel = eff_addr[0];
  assign pins_w   = pin_in;
  assign pin_oe   = oe_w;
  assign pin_out  = drv_w;

  gpx_pointer #(.ADDR_W(ADDR_W), .LOAD_W(LOAD_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .access(wr_stb | rd_req), .eff_addr(eff_addr), .ptr_q(ptr_q)
  );

  gpx_store #(.PORT_W(PORT_W), .NPORT(NPORT)) u_store (
    .clk(clk), .rst(rst), .we(wr_stb), .kind(kind), .port_sel(port_sel),
    .wdata(wr_data), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q),
    .pin_oe(oe_w), .pin_out(drv_w)
  );

  gpx_readpath #(.PORT_W(PORT_W), .NPORT(NPORT)) u_rd (
    .clk(clk), .rst(rst), .pin_in(pins_w), .out_q(out_q), .pol_q(pol_q),
    .dir_q(dir_q), .rd_req(rd_req), .kind(kind), .port_sel(port_sel),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  p_undriven_r6: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ~pin_oe) == '0));
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/gpx_regbank_test.sv
module gpx_regbank_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_load = 1'b0;
  logic [3:0]  ptr_val = '0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_oe, pin_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpx_regbank uut (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one edge per call: inputs set at a falling edge, cleared at the next
  task automatic op(bit ld, logic [3:0] a, bit wr, logic [7:0] d, bit rd);
    @(negedge clk);
    ptr_load = ld; ptr_val = a; wr_stb = wr; wr_data = d; rd_req = rd;
    @(negedge clk);
    ptr_load = 0; wr_stb = 0; rd_req = 0;
  endtask

  task automatic load(logic [3:0] a);   op(1, a, 0, 8'h00, 0); endtask
  task automatic wbyte(logic [7:0] d);  op(0, 4'h0, 1, d, 0); endtask
  task automatic rbyte(output logic [7:0] d);
    op(0, 4'h0, 0, 8'h00, 1);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    op(1, 4'd6, 1, 8'h00, 0);
    op(0, 4'd0, 1, 8'h00, 0);
    chk("R1 oe in reset", pin_oe, 16'h0000);
    @(negedge clk); rst = 0;
    chk("R1 oe after reset", pin_oe, 16'h0000);
    chk("R1 pin_out after reset", pin_out, 16'h0000);
    load(4'd2);
    rbyte(v); chk("R1 out0 default", v, 8'hFF);
    rbyte(v); chk("R1 out1 default", v, 8'hFF);
    load(4'd4);
    rbyte(v); chk("R1 pol0 default", v, 8'h00);
    load(4'd7);
    rbyte(v); chk("R1 dir1 default", v, 8'hFF);
  endtask

  task automatic t_map_toggle();
    logic [7:0] v;
    load(4'd3);
    wbyte(8'h11); wbyte(8'h22); wbyte(8'h33);
    load(4'd2);
    rbyte(v); chk("R3 reg2 after 3/2/3", v, 8'h22);
    rbyte(v); chk("R3 reg3 after 3/2/3", v, 8'h33);
    rbyte(v); chk("R3 third read back to reg2", v, 8'h22);
    load(4'd5); wbyte(8'hA5);
    load(4'd4);
    rbyte(v); chk("R2 addr4 is pol0", v, 8'h00);
    rbyte(v); chk("R2 addr5 is pol1", v, 8'hA5);
    load(4'd5); wbyte(8'h00);
  endtask

  task automatic t_input_pol();
    logic [7:0] v;
    pin_in = 16'h5AC3;
    load(4'd4); wbyte(8'h00); wbyte(8'hFF);
    load(4'd0);
    rbyte(v); chk("R4 in0 no inversion", v, 8'hC3);
    rbyte(v); chk("R4 in1 inverted", v, 8'hA5);
    load(4'd6); wbyte(8'h00);
    load(4'd0);
    rbyte(v); chk("R4 in0 while output", v, 8'hC3);
    load(4'd6); wbyte(8'hFF);
    load(4'd5); wbyte(8'h00);
  endtask

  task automatic t_input_ro();
    logic [7:0] v;
    load(4'd0); wbyte(8'h77); wbyte(8'h66);
    rbyte(v); chk("R5 in0 unchanged by write", v, 8'hC3);
    rbyte(v); chk("R5 in1 unchanged by write", v, 8'h5A);
    load(4'd2);
    rbyte(v); chk("R5 out0 untouched", v, 8'h22);
    chk("R5 oe untouched", pin_oe, 16'h0000);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    load(4'd2); wbyte(8'hF0); wbyte(8'h0F);
    load(4'd6); wbyte(8'h3C); wbyte(8'hFF);
    chk("R6 oe port0 mixed", pin_oe, 16'h00C3);
    chk("R6 pin_out masked", pin_out, 16'h00C0);
    load(4'd7); wbyte(8'h00);
    chk("R6 oe port1 all out", pin_oe, 16'hFFC3);
    chk("R6 pin_out port1 driven", pin_out, 16'h0FC0);
    pin_in = 16'h0000;
    load(4'd2);
    rbyte(v); chk("R7 out0 is latch not pin", v, 8'hF0);
    rbyte(v); chk("R7 out1 is latch not pin", v, 8'h0F);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    load(4'b1011);
    rbyte(v); chk("R8 load 11 selects 3", v, 8'h0F);
    rbyte(v); chk("R8 partner of 3", v, 8'hF0);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    load(4'd5); wbyte(8'h3E);
    load(4'd0);
    op(1, 4'd5, 0, 8'h00, 1);
    chk("R9 load+read uses loaded addr", rd_data, 8'h3E);
    rbyte(v); chk("R9 next access is partner", v, 8'h00);
    op(1, 4'd7, 1, 8'hF0, 0);
    chk("R9 load+write hits dir1", pin_oe, 16'h0FC3);
  endtask

  task automatic t_hold();
    pin_in = 16'h00A6;
    @(negedge clk);
    load(4'd0);
    op(0, 4'd0, 0, 8'h00, 1);
    chk("R11 valid after request", rd_valid, 1'b1);
    chk("R4 sampled byte", rd_data, 8'hA6);
    pin_in = 16'h0059;
    repeat (3) @(negedge clk);
    chk("R10 byte stable after pin change", rd_data, 8'hA6);
    chk("R11 valid drops", rd_valid, 1'b0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    load(4'd2);
    op(0, 4'd0, 1, 8'h55, 1);
    chk("R12 read returns old", rd_data, 8'hF0);
    rbyte(v); chk("R12 one pointer step", v, 8'h0F);
    load(4'd2);
    rbyte(v); chk("R12 write took effect", v, 8'h55);
    chk("R12 pin_out follows", pin_out[7:0], 8'h41);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_map_toggle();
    t_input_pol();
    t_input_ro();
    t_direction();
    t_mask();
    t_same_cycle();
    t_hold();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule